// File: doc/BRIEF.md
# Reset Escalation Controller

This block watches the stream of reset events a chip goes through and decides when a run of functional resets has become a problem. Each functional reset event raises a functional count. When that count meets a programmable functional limit, the block raises a one-cycle request for a destructive reset in place of another functional reset. Destructive resets are counted against a second programmable limit. When that limit is met, the block raises a sticky hang flag, so the device stays held instead of restarting.

Software programs both limits through a small write port. It can also zero the functional count by writing the all-ones pattern to a dedicated select. A limit of zero switches off its stage. Only the power-on reset input clears the destructive count and the hang flag. All counts and limits can be read on output pins. Every pin is a plain level or a one-cycle pulse, and there is no handshake.

Top module: `rst_escalation_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), both counts are 0, both limits are 15, and `hang` and `dest_req` are low.
- R2: A `func_evt` pulse that neither escalates nor meets a destructive event raises `func_cnt` by one from the next cycle. The count holds at 15 and does not wrap.
- R3: A `func_evt` pulse escalates when the functional limit is non-zero and the incremented count is at or above it. An escalation that does not cause a hang drives `dest_req` high for one cycle. It sets `func_cnt` to 0 and raises `dest_cnt` by one.
- R4: A functional limit of 0 never escalates, and `dest_req` stays low.
- R5: A write with `wr_sel`=2 and `wr_data`=15 sets `func_cnt` to 0. A write with `wr_sel`=2 and any other data leaves `func_cnt` unchanged.
- R6: When a `func_evt` and a clear write fall in the same cycle, the event wins. The count is then the old count plus one, and from 0 it ends at 1.
- R7: A `dest_evt` pulse sets `func_cnt` to 0 and raises `dest_cnt` by one. `dest_cnt` holds at 15. An external destructive event never raises `dest_req`.
- R8: A destructive occurrence raises `hang` when the destructive limit is non-zero and the incremented `dest_cnt` is at or above it. A destructive occurrence is either a `dest_evt` or an escalation. When this occurrence is an escalation, `dest_req` stays low. `hang` stays high until power-on reset. While `hang` is high, `func_evt`, `dest_evt` and clear writes have no effect on the counts.
- R9: A destructive limit of 0 never raises `hang`.
- R10: A write with `wr_sel`=0 loads the functional limit from `wr_data`. A write with `wr_sel`=1 loads the destructive limit. The new value appears on `func_thr` or `dest_thr` from the next cycle. `wr_sel`=3 does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| func_evt | input | 1 | One-cycle pulse per functional reset event |
| dest_evt | input | 1 | One-cycle pulse per destructive reset event |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 functional limit, 1 destructive limit, 2 functional count clear |
| wr_data | input | CW | Write data |
| dest_req | output | 1 | One-cycle destructive reset request on escalation |
| hang | output | 1 | Sticky hold-in-reset flag |
| func_cnt | output | CW | Functional reset count |
| dest_cnt | output | CW | Destructive reset count |
| func_thr | output | CW | Functional limit |
| dest_thr | output | CW | Destructive limit |

## Verification
A functional count that is wrong shows up as an early or missing `dest_req`. This appears on the very event that should or should not have escalated, which is one cycle after the pulse, and the count pins also show it at once. A destructive count that is wrong moves the cycle in which `hang` rises. Because the flag is sticky, a hang that is entered wrongly stays visible until power-on reset. Missed freezing while hung shows as a count that keeps moving after `hang` rose.

// File: rtl/rst_esc_pkg.sv
package rst_esc_pkg;
  typedef enum logic [1:0] {
    SEL_FTHR = 2'd0,
    SEL_DTHR = 2'd1,
    SEL_FCLR = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/rst_esc_cfg.sv
module rst_esc_cfg
  import rst_esc_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] fthr,
  output logic [CW-1:0] dthr,
  output logic          fclr
);
  localparam logic [CW-1:0] ALL1 = {CW{1'b1}};

  // clear only on the all-ones pattern; anything else is dropped
  assign fclr = wr_en && (wr_sel == SEL_FCLR) && (wr_data == ALL1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fthr <= ALL1;
      dthr <= ALL1;
    end else if (wr_en) begin
      if (wr_sel == SEL_FTHR) fthr <= wr_data;
      if (wr_sel == SEL_DTHR) dthr <= wr_data;
    end
  end

  // R10: limit register follows a write of its select
  a_r10_fthr_load: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_sel == SEL_FTHR) |=> (fthr == $past(wr_data)));
  a_r10_dthr_load: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_sel == SEL_DTHR) |=> (dthr == $past(wr_data)));
endmodule

// File: rtl/rst_esc_func.sv
module rst_esc_func #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          func_evt,
  input  logic          dest_evt,
  input  logic          fclr,
  input  logic          hang,
  input  logic [CW-1:0] fthr,
  output logic [CW-1:0] cnt,
  output logic          esc
);
  localparam logic [CW-1:0] ALL1 = {CW{1'b1}};

  logic [CW-1:0] inc;
  assign inc = (cnt == ALL1) ? cnt : cnt + 1'b1;
  assign esc = func_evt && !hang && (fthr != '0) && (inc >= fthr);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 cnt <= '0;
    else if (hang)              cnt <= cnt;
    else if (dest_evt || esc)   cnt <= '0;
    else if (func_evt)          cnt <= inc;   // event beats clear (R6)
    else if (fclr)              cnt <= '0;
  end

  // R2: saturation
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (!por_n)
    (cnt == ALL1 && func_evt && !esc && !dest_evt && !hang) |=> (cnt == ALL1));
  // R5: clear alone zeroes the count
  a_r5_clear: assert property (@(posedge clk) disable iff (!por_n)
    (fclr && !func_evt && !dest_evt && !hang) |=> (cnt == '0));
  // R4: zero limit never escalates
  a_r4_zero_off: assert property (@(posedge clk) disable iff (!por_n)
    (fthr == '0) |-> !esc);
endmodule

// File: rtl/rst_esc_dest.sv
module rst_esc_dest #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          dest_evt,
  input  logic          esc,
  input  logic [CW-1:0] dthr,
  output logic [CW-1:0] cnt,
  output logic          hang,
  output logic          req
);
  localparam logic [CW-1:0] ALL1 = {CW{1'b1}};

  logic          occ, enter;
  logic [CW-1:0] inc;

  assign occ   = !hang && (dest_evt || esc);
  assign inc   = (cnt == ALL1) ? cnt : cnt + 1'b1;
  assign enter = occ && (dthr != '0) && (inc >= dthr);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt  <= '0;
      hang <= 1'b0;
      req  <= 1'b0;
    end else begin
      if (occ) cnt <= inc;
      hang <= hang || enter;
      req  <= esc && !enter;
    end
  end

  // R8: hang is sticky and freezes the count
  a_r8_hang_sticky: assert property (@(posedge clk) disable iff (!por_n)
    hang |=> hang);
  a_r8_hang_frozen: assert property (@(posedge clk) disable iff (!por_n)
    hang |=> $stable(cnt));
  // R9: zero limit never hangs
  a_r9_zero_off: assert property (@(posedge clk) disable iff (!por_n)
    (!hang && dthr == '0) |=> !hang);
endmodule

// File: rtl/rst_escalation_ctrl.sv
module rst_escalation_ctrl #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          func_evt,
  input  logic          dest_evt,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic          dest_req,
  output logic          hang,
  output logic [CW-1:0] func_cnt,
  output logic [CW-1:0] dest_cnt,
  output logic [CW-1:0] func_thr,
  output logic [CW-1:0] dest_thr
);
  logic fclr, esc;

  rst_esc_cfg #(.CW(CW)) u_cfg (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .fthr(func_thr), .dthr(dest_thr), .fclr(fclr)
  );

  rst_esc_func #(.CW(CW)) u_func (
    .clk(clk), .por_n(por_n), .func_evt(func_evt), .dest_evt(dest_evt),
    .fclr(fclr), .hang(hang), .fthr(func_thr), .cnt(func_cnt), .esc(esc)
  );

  rst_esc_dest #(.CW(CW)) u_dest (
    .clk(clk), .por_n(por_n), .dest_evt(dest_evt), .esc(esc),
    .dthr(dest_thr), .cnt(dest_cnt), .hang(hang), .req(dest_req)
  );

  // R3: a request always comes with a zeroed functional count and a counted destructive
  a_r3_req_zero: assert property (@(posedge clk) disable iff (!por_n)
    dest_req |-> (func_cnt == '0 && dest_cnt != '0));
  // R8: request and hang never rise together
  a_r8_no_req_on_hang: assert property (@(posedge clk) disable iff (!por_n)
    $rose(hang) |-> !dest_req);
  // R7: an external destructive event never requests
  a_r7_no_req: assert property (@(posedge clk) disable iff (!por_n)
    (dest_evt && !func_evt) |=> !dest_req);
endmodule

// File: tb/sim_rst_escalation_ctrl.sv
module sim_rst_escalation_ctrl;
  localparam int CW = 4;
  logic clk = 0, por_n = 0, func_evt = 0, dest_evt = 0, wr_en = 0;
  logic [1:0] wr_sel = 2'd3;
  logic [CW-1:0] wr_data = '0;
  logic dest_req, hang;
  logic [CW-1:0] func_cnt, dest_cnt, func_thr, dest_thr;
  int checks = 0, errors = 0, req_seen = 0;

  always #5 clk = ~clk;

  rst_escalation_ctrl #(.CW(CW)) u0 (.*);

  always @(negedge clk) if (dest_req) req_seen++;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit f, bit d, bit w, int sel, int data);
    @(negedge clk);
    func_evt = f; dest_evt = d; wr_en = w; wr_sel = sel[1:0]; wr_data = data[CW-1:0];
    @(negedge clk);
    func_evt = 0; dest_evt = 0; wr_en = 0; wr_sel = 2'd3;
  endtask

  task automatic t_reset();
    chk("R1 func_cnt", func_cnt, 0); chk("R1 dest_cnt", dest_cnt, 0);
    chk("R1 func_thr", func_thr, 15); chk("R1 dest_thr", dest_thr, 15);
    chk("R1 hang", hang, 0); chk("R1 dest_req", dest_req, 0);
  endtask

  task automatic t_count();
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 3, 0);
    chk("R2 count 3", func_cnt, 3);
  endtask

  task automatic t_clear();
    cyc(0, 0, 1, 2, 5);
    chk("R5 non-F ignored", func_cnt, 3);
    cyc(0, 0, 1, 3, 15);
    chk("R10 sel3 no effect", func_cnt, 3);
    cyc(0, 0, 1, 2, 15);
    chk("R5 clear", func_cnt, 0);
  endtask

  task automatic t_tie();
    cyc(1, 0, 1, 2, 15);
    chk("R6 event wins", func_cnt, 1);
  endtask

  task automatic t_disable();
    int r0;
    cyc(0, 0, 1, 0, 0);
    chk("R10 func_thr 0", func_thr, 0);
    r0 = req_seen;
    for (int i = 0; i < 17; i++) cyc(1, 0, 0, 3, 0);
    chk("R2 saturate", func_cnt, 15);
    chk("R4 no request", req_seen - r0, 0);
    chk("R4 dest untouched", dest_cnt, 0);
  endtask

  task automatic t_escalate();
    cyc(0, 0, 1, 0, 3);
    cyc(0, 0, 1, 2, 15);
    cyc(1, 0, 0, 3, 0); cyc(1, 0, 0, 3, 0);
    chk("R3 below limit", func_cnt, 2);
    chk("R3 no early req", dest_req, 0);
    @(negedge clk); func_evt = 1;
    @(negedge clk); func_evt = 0;
    chk("R3 req pulse", dest_req, 1);
    chk("R3 func zeroed", func_cnt, 0);
    chk("R3 dest counted", dest_cnt, 1);
    @(negedge clk);
    chk("R3 one cycle", dest_req, 0);
  endtask

  task automatic t_dest_evt();
    int r0;
    cyc(1, 0, 0, 3, 0);
    r0 = req_seen;
    cyc(0, 1, 0, 3, 0);
    chk("R7 func zeroed", func_cnt, 0);
    chk("R7 dest inc", dest_cnt, 2);
    chk("R7 no req", req_seen - r0, 0);
  endtask

  task automatic t_dest_off();
    cyc(0, 0, 1, 1, 0);
    chk("R10 dest_thr 0", dest_thr, 0);
    for (int i = 0; i < 15; i++) cyc(0, 1, 0, 3, 0);
    chk("R7 dest saturate", dest_cnt, 15);
    chk("R9 no hang", hang, 0);
  endtask

  task automatic t_hang();
    int r0;
    cyc(0, 0, 1, 1, 15);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 0, 0, 3, 0); cyc(1, 0, 0, 3, 0);
    cyc(0, 0, 1, 0, 3);
    r0 = req_seen;
    cyc(1, 0, 0, 3, 0);
    chk("R8 hang set", hang, 1);
    chk("R8 no req", req_seen - r0, 0);
    chk("R8 func zeroed", func_cnt, 0);
    cyc(1, 0, 0, 3, 0); cyc(1, 0, 0, 3, 0);
    chk("R8 func frozen", func_cnt, 0);
    cyc(0, 1, 0, 3, 0);
    chk("R8 dest frozen", dest_cnt, 15);
    repeat (3) @(negedge clk);
    chk("R8 sticky", hang, 1);
    por_n = 0; @(negedge clk); por_n = 1; @(negedge clk);
    t_reset();
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_clear();
    t_tie();
    t_disable();
    t_escalate();
    t_dest_evt();
    t_dest_off();
    t_hang();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule